// File: doc/BRIEF.md
# Serial-Loaded Life Grid Engine

This block runs the two-state cellular automaton with the birth-on-three, survive-on-two-or-three rule over a small rectangular grid. The grid is 8 by 8 by default. The starting pattern goes in one cell per clock through a single data bit, in row-major order. A start pulse then seals the pattern. From that point the block runs by itself. It computes a whole new generation in one clock cycle. It then spends one clock per cell streaming that generation out, and tags each cell with its 1-based position.

Two shift registers hold the grid. The load register takes the serial pattern, and its contents feed a bank of per-cell rule evaluators. The update register captures all evaluator outputs at once. During the streaming phase, the update register shifts its cells out and feeds them back into the load register, so that register holds the same generation again when streaming ends. The block repeats update and stream until reset.

Top module: `life_grid_engine`

## Requirements
- R1: In the load phase, each clock with `start_in` low shifts `data_in` into the grid. The first of 64 loaded bits becomes cell 1 (row 0, column 0) and the last becomes cell 64 (row 7, column 7).
- R2: If more than 64 bits are loaded before start, only the 64 most recent are kept, in arrival order. The oldest bits are discarded.
- R3: A clock with `start_in` high in the load phase ends loading. The `data_in` value in that cycle is not stored.
- R4: After loading ends, `data_in` and `start_in` have no effect on any output until reset.
- R5: The update phase lasts exactly one clock and directly follows the start cycle or the end of a streaming phase. During it, `loc_out` is 0 and `cell_out` is 0.
- R6: A live cell stays live with 2 or 3 live neighbours. A dead cell becomes live with exactly 3. All other cells are dead in the next generation.
- R7: Positions outside the grid count as dead neighbours. The grid edges do not wrap.
- R8: The streaming phase lasts exactly 64 clocks. In its k-th clock (k = 1..64), `loc_out` equals k and `cell_out` is the new state of cell k, counted row-major from 1.
- R9: The block alternates update and streaming with no further input. Each generation is computed from the previous one.
- R10: If `start_in` is high on the first clock after reset is released, the game starts at once from the cleared (all-dead) grid.
- R11: A synchronous active-high `rst` clears both registers and selects the load phase. In the load phase `loc_out` and `cell_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 1 | Serial cell value while loading (1 = live) |
| start_in | input | 1 | Ends loading and starts the game |
| cell_out | output | 1 | Value of the streamed cell |
| loc_out | output | 7 | 1-based row-major position of the streamed cell, 0 outside streaming |

## Verification
A horizontal three-cell oscillator near the centre is run for several generations. Because it flips between horizontal and vertical, it separates a correct rule and a correct feedback path from a stale or transposed grid. Patterns placed against the top, right and bottom borders show whether missing neighbours are treated as dead or wrapped around. A loaded sequence longer than the grid, a set data bit during the start cycle, and input toggling while the game runs each test which bits are allowed to reach the grid. A pseudo-random dense grid checks the rule over many neighbour counts, and holding start through reset checks the cleared-grid restart.

// File: rtl/life_pkg.sv
package life_pkg;

  typedef enum logic [1:0] {
    PH_LOAD   = 2'd0,
    PH_UPDATE = 2'd1,
    PH_STREAM = 2'd2
  } phase_e;

  // number of set bits in a 3x3 neighbourhood vector (centre slot is zero)
  function automatic logic [3:0] count_live(input logic [8:0] hood);
    logic [3:0] n;
    n = 4'd0;
    for (int i = 0; i < 9; i++) begin
      n = n + {3'b000, hood[i]};
    end
    return n;
  endfunction

  // birth on three, survival on two or three
  function automatic logic next_state(input logic alive, input logic [3:0] n);
    return (n == 4'd3) || (alive && (n == 4'd2));
  endfunction

endpackage

// File: rtl/life_rule_array.sv
module life_rule_array #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic [ROWS*COLS-1:0] grid_cur,
  output logic [ROWS*COLS-1:0] grid_nxt
);
  import life_pkg::*;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int SELF = r * COLS + c;
      logic [8:0] hood;
      logic [3:0] live_n;

      for (genvar k = 0; k < 9; k++) begin : g_nb
        localparam int RR = r + (k / 3) - 1;
        localparam int CC = c + (k % 3) - 1;
        if (k != 4 && RR >= 0 && RR < ROWS && CC >= 0 && CC < COLS) begin : g_in
          assign hood[k] = grid_cur[RR * COLS + CC];
        end else begin : g_out
          assign hood[k] = 1'b0;
        end
      end

      assign live_n = count_live(hood);
      assign grid_nxt[SELF] = next_state(grid_cur[SELF], live_n);

      always_comb begin
        assert (live_n <= 4'd8) else $error("p_hood_max_r6 violated");
      end
    end
  end

endmodule

// File: rtl/life_phase_ctrl.sv
module life_phase_ctrl #(
  parameter int CELLS = 64,
  localparam int CNT_W = $clog2(CELLS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_in,
  output life_pkg::phase_e   phase,
  output logic [CNT_W-1:0]   slot,
  output logic               shift_load_en,
  output logic               capture_en,
  output logic               stream_en,
  output logic               stream_last
);
  import life_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(CELLS - 1);

  phase_e phase_q;
  logic [CNT_W-1:0] slot_q;
  logic start_evt;

  assign phase         = phase_q;
  assign slot          = slot_q;
  assign start_evt     = (phase_q == PH_LOAD) && start_in;
  assign shift_load_en = (phase_q == PH_LOAD) && !start_in;
  assign capture_en    = (phase_q == PH_UPDATE);
  assign stream_en     = (phase_q == PH_STREAM);
  assign stream_last   = stream_en && (slot_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_LOAD;
      slot_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_LOAD: begin
          if (start_evt) phase_q <= PH_UPDATE;
        end
        PH_UPDATE: begin
          phase_q <= PH_STREAM;
          slot_q  <= '0;
        end
        PH_STREAM: begin
          if (stream_last) begin
            phase_q <= PH_UPDATE;
            slot_q  <= '0;
          end else begin
            slot_q <= slot_q + CNT_W'(1);
          end
        end
        default: phase_q <= PH_LOAD;
      endcase
    end
  end

  // R5: update occupies a single cycle
  p_update_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    capture_en |=> stream_en && (slot == '0));

  // R4: once running, never back to loading without reset
  p_no_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_LOAD) |=> (phase != PH_LOAD));

  // R8: streaming continues until the last slot
  p_stream_len_r8: assert property (@(posedge clk) disable iff (rst)
    (stream_en && !stream_last) |=> stream_en && (slot == $past(slot) + CNT_W'(1)));

  // R9: end of streaming leads back to update
  p_loop_back_r9: assert property (@(posedge clk) disable iff (rst)
    stream_last |=> capture_en);

endmodule

// File: rtl/life_shift_store.sv
module life_shift_store #(
  parameter int CELLS = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             data_in,
  input  logic             shift_load_en,
  input  logic             capture_en,
  input  logic             stream_en,
  input  logic [CELLS-1:0] grid_nxt,
  output logic [CELLS-1:0] load_q,
  output logic             head_bit
);

  logic [CELLS-1:0] upd_q;

  assign head_bit = upd_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
      upd_q  <= '0;
    end else if (shift_load_en) begin
      load_q <= {data_in, load_q[CELLS-1:1]};
    end else if (capture_en) begin
      upd_q <= grid_nxt;
    end else if (stream_en) begin
      upd_q  <= {1'b0, upd_q[CELLS-1:1]};
      load_q <= {upd_q[0], load_q[CELLS-1:1]};
    end
  end

  // R1: a load cycle places the input bit at the newest position
  p_load_shift_r1: assert property (@(posedge clk) disable iff (rst)
    shift_load_en |=> load_q[CELLS-1] == $past(data_in));

  // R9: streamed cells are fed back into the load register
  p_feedback_r9: assert property (@(posedge clk) disable iff (rst)
    stream_en |=> load_q[CELLS-1] == $past(head_bit));

  // R3/R4: grid is frozen outside loading and streaming
  p_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    (!shift_load_en && !stream_en) |=> $stable(load_q));

endmodule

// File: rtl/life_grid_engine.sv
module life_grid_engine #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int CELLS = ROWS * COLS,
  localparam int CNT_W = $clog2(CELLS),
  localparam int LOC_W = $clog2(CELLS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             data_in,
  input  logic             start_in,
  output logic             cell_out,
  output logic [LOC_W-1:0] loc_out
);
  import life_pkg::*;

  phase_e           phase;
  logic [CNT_W-1:0] slot;
  logic             shift_load_en;
  logic             capture_en;
  logic             stream_en;
  logic             stream_last;
  logic [CELLS-1:0] load_q;
  logic [CELLS-1:0] grid_nxt;
  logic             head_bit;

  life_phase_ctrl #(.CELLS(CELLS)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start_in     (start_in),
    .phase        (phase),
    .slot         (slot),
    .shift_load_en(shift_load_en),
    .capture_en   (capture_en),
    .stream_en    (stream_en),
    .stream_last  (stream_last)
  );

  life_rule_array #(.ROWS(ROWS), .COLS(COLS)) u_rule (
    .grid_cur(load_q),
    .grid_nxt(grid_nxt)
  );

  life_shift_store #(.CELLS(CELLS)) u_store (
    .clk          (clk),
    .rst          (rst),
    .data_in      (data_in),
    .shift_load_en(shift_load_en),
    .capture_en   (capture_en),
    .stream_en    (stream_en),
    .grid_nxt     (grid_nxt),
    .load_q       (load_q),
    .head_bit     (head_bit)
  );

  assign cell_out = stream_en ? head_bit : 1'b0;
  assign loc_out  = stream_en ? (LOC_W'(slot) + LOC_W'(1)) : '0;

  // R5/R11: outside streaming the outputs rest at zero
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_STREAM) |-> (loc_out == '0) && !cell_out);

  // R8: positions stay within 1..CELLS while streaming
  p_loc_range_r8: assert property (@(posedge clk) disable iff (rst)
    stream_en |-> (loc_out >= LOC_W'(1)) && (loc_out <= LOC_W'(CELLS)));

  // R8: the last position is followed by an update cycle
  p_last_loc_r8: assert property (@(posedge clk) disable iff (rst)
    (loc_out == LOC_W'(CELLS)) |=> (loc_out == '0));

endmodule

// File: tb/life_grid_engine_tb.sv
module life_grid_engine_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic data_in = 1'b0;
  logic start_in = 1'b0;
  logic cell_out;
  logic [6:0] loc_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit model [64];

  always #10 clk = ~clk;

  life_grid_engine dut_i (
    .clk(clk), .rst(rst), .data_in(data_in), .start_in(start_in),
    .cell_out(cell_out), .loc_out(loc_out)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // bench model: pad the grid with a dead border, then count
  task automatic model_step();
    bit pad [10][10];
    bit nxt [64];
    for (int r = 0; r < 10; r++)
      for (int c = 0; c < 10; c++) pad[r][c] = 0;
    for (int i = 0; i < 64; i++) pad[i/8 + 1][i%8 + 1] = model[i];
    for (int r = 1; r <= 8; r++) begin
      for (int c = 1; c <= 8; c++) begin
        int n = 0;
        n = pad[r-1][c-1] + pad[r-1][c] + pad[r-1][c+1] + pad[r][c-1]
          + pad[r][c+1] + pad[r+1][c-1] + pad[r+1][c] + pad[r+1][c+1];
        nxt[(r-1)*8 + (c-1)] = (n == 3) || (pad[r][c] && n == 2);
      end
    end
    for (int i = 0; i < 64; i++) model[i] = nxt[i];
  endtask

  task automatic do_reset(input bit hold_start);
    rst = 1'b1; start_in = hold_start; data_in = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_grid(input logic [63:0] g);
    for (int i = 0; i < 64; i++) begin
      data_in = g[i];
      model[i] = g[i];
      @(negedge clk);
    end
  endtask

  // call at a negedge where the start edge has just been applied
  task automatic press_start(input bit din_during);
    data_in = din_during; start_in = 1'b1;
    @(negedge clk);
    start_in = 1'b0; data_in = 1'b0;
  endtask

  // entered at a negedge inside an update cycle
  task automatic run_gens(input int gens, input string req, input bit noisy);
    for (int g = 0; g < gens; g++) begin
      chk("R5", "update loc", int'(loc_out), 0);
      chk("R5", "update cell", int'(cell_out), 0);
      model_step();
      if (noisy) begin data_in = ~data_in; start_in = ~start_in; end
      @(negedge clk);
      for (int k = 0; k < 64; k++) begin
        chk("R8", "loc", int'(loc_out), k + 1);
        chk(req, $sformatf("gen %0d cell %0d", g + 1, k + 1), int'(cell_out), int'(model[k]));
        if (noisy) begin data_in = k[0]; start_in = k[1]; end
        @(negedge clk);
      end
    end
    data_in = 1'b0; start_in = 1'b0;
  endtask

  function automatic logic [63:0] cells(input int idx [], input int cnt);
    logic [63:0] g = '0;
    for (int i = 0; i < cnt; i++) g[idx[i]] = 1'b1;
    return g;
  endfunction

  task automatic t_reset();
    do_reset(1'b0);
    @(negedge clk);
    chk("R11", "load loc", int'(loc_out), 0);
    chk("R11", "load cell", int'(cell_out), 0);
  endtask

  task automatic t_blinker();
    int idx [] = '{26, 27, 28};
    do_reset(1'b0);
    load_grid(cells(idx, 3));
    press_start(1'b0);
    run_gens(3, "R6_R9_R1", 1'b0);
  endtask

  task automatic t_edges();
    int idx [] = '{0, 1, 2, 31, 39, 47, 58, 59, 60, 56, 48};
    do_reset(1'b0);
    load_grid(cells(idx, 11));
    press_start(1'b0);
    run_gens(2, "R7", 1'b0);
  endtask

  task automatic t_overflow();
    logic [63:0] g = 64'hF0F0_3C3C_0FF0_A5C3;
    logic [5:0] extra = 6'b101101;
    do_reset(1'b0);
    load_grid(g);
    for (int i = 0; i < 6; i++) begin
      data_in = extra[i];
      @(negedge clk);
    end
    for (int i = 0; i < 64; i++) model[i] = (i < 58) ? g[i+6] : extra[i-58];
    press_start(1'b0);
    run_gens(1, "R2", 1'b0);
  endtask

  task automatic t_start_drop();
    int idx [] = '{9, 10, 17, 18, 36, 44, 52};
    do_reset(1'b0);
    load_grid(cells(idx, 7));
    press_start(1'b1);
    run_gens(1, "R3", 1'b0);
  endtask

  task automatic t_noise();
    logic [63:0] g;
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 64; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      g[i] = lfsr[0] | lfsr[3];
    end
    do_reset(1'b0);
    load_grid(g);
    press_start(1'b0);
    run_gens(2, "R4", 1'b1);
    run_gens(1, "R6", 1'b0);
  endtask

  task automatic t_start_at_reset();
    do_reset(1'b1);
    for (int i = 0; i < 64; i++) model[i] = 0;
    @(negedge clk);
    start_in = 1'b0;
    run_gens(1, "R10_R11", 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_blinker();
    t_edges();
    t_overflow();
    t_start_drop();
    t_noise();
    t_start_at_reset();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule